// File: doc/BRIEF.md
# Serial DAC Input Register Interface

This block is the digital front end of a three-wire serial digital-to-analog converter. A serial clock, a serial data line and an active-low select arrive asynchronously. A fast system clock samples them, and the block detects serial clock and select edges from the synchronised samples. While the select is low, each rising serial clock edge moves one bit into a 16-bit shift register, most significant bit first. When the select returns high, the ten data bits above the two sub-LSB positions are latched into a parallel 10-bit code register. That register feeds the converter's analog core.

Bits that leave the top of the shift register are presented on a serial output on falling serial clock edges, so several devices can be chained. A one-cycle strobe marks each code update. A flag marks a frame whose bit count was neither 12 nor 16, so the controller can catch clocking faults. The shortest frame a controller may send is 12 bits. A 16-bit frame adds four leading dummy bits, which chaining needs.

Top module: `sdac_frontend`

## Requirements
- R1: After reset, code_o is 0, load_o is 0, frame_err_o is 0 and sdo_o is 0.
- R2: While csn_i is low, each rising edge of sclk_i shifts sdi_i into the shift register. After a 16-bit frame, code_o holds frame bits 5 to 14 (bit 1 is sent first), and bit 5 is the MSB of the code.
- R3: After a 12-bit frame, code_o holds frame bits 1 to 10, and bit 1 is the MSB of the code.
- R4: The four leading dummy bits of a 16-bit frame and the two final sub-LSB bits of any frame have no effect on code_o.
- R5: Serial clock edges while csn_i is high shift nothing, change no count and leave sdo_o unchanged.
- R6: code_o and load_o change only on a csn_i rising edge. With two synchroniser stages, both update at the third system clock edge after the pin rises. load_o is high for exactly one cycle.
- R7: At each load, frame_err_o becomes 1 if the number of rising serial clock edges in the frame was neither 12 nor 16, and 0 otherwise. It holds that value until the next load. On an error the code is still taken from the most recent 12 bits shifted in, including bits from earlier frames.
- R8: A bit shifted in on rising serial clock edge n is driven on sdo_o at the falling edge that follows rising edge n+16, counting edges across frames. sdo_o changes only on falling edges while the select is low, and otherwise holds its value.
- R9: A serial clock edge seen in the same system cycle as the select rising edge still takes effect. A final rise is counted and shifted before the latch. A final fall still drives sdo_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4 times the serial clock rate |
| rst_n | input | 1 | Active-low power-on reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in, MSB first |
| csn_i | input | 1 | Active-low select, asynchronous |
| sdo_o | output | 1 | Chained serial data out |
| code_o | output | 10 | Latched converter code |
| load_o | output | 1 | One-cycle strobe on each code update |
| frame_err_o | output | 1 | Last frame had a bit count other than 12 or 16 |

## Verification
Two functions can fall in the same system cycle: the latch on the select's rising edge, and a serial clock edge. The bench provokes this by moving the last serial clock edge of a frame and the select together on one system clock edge, once with a rising edge and once with a falling edge. For the rising edge it checks that a 12-bit frame still loads the right code with no frame error. For the falling edge it checks that the chained output still presents the expected bit of the previous frame. A behavioural reference model also judges every output on every clock.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    typedef struct packed {
        logic csn;
        logic sclk;
        logic sdi;
    } pins_t;

    localparam pins_t PINS_IDLE = '{csn: 1'b1, sclk: 1'b0, sdi: 1'b0};

    typedef struct packed {
        logic sclk_rise;
        logic sclk_fall;
        logic cs_rise;
        logic cs_fall;
        logic sel;
        logic sdi;
    } evt_t;

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync
    import sdac_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  pins_t pins_i,
    output pins_t pins_o
);
    pins_t stage_d [STAGES];
    pins_t stage_q [STAGES];

    always_comb begin
        stage_d[0] = pins_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= PINS_IDLE;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign pins_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdac_edge.sv
module sdac_edge
    import sdac_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  pins_t now_i,
    output evt_t  evt_o
);
    pins_t prev_d, prev_q;

    always_comb begin
        prev_d          = now_i;
        evt_o.sclk_rise = now_i.sclk & ~prev_q.sclk;
        evt_o.sclk_fall = ~now_i.sclk & prev_q.sclk;
        evt_o.cs_rise   = now_i.csn & ~prev_q.csn;
        evt_o.cs_fall   = ~now_i.csn & prev_q.csn;
        evt_o.sel       = ~prev_q.csn;
        evt_o.sdi       = now_i.sdi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= PINS_IDLE;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift
    import sdac_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int SHORT_W = 12,
    parameter int CNT_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  evt_t               evt_i,
    output logic [SHORT_W-1:0] win_o,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               sdo_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic [CNT_W-1:0]   cnt;
        logic               spill;
        logic               sdo;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (evt_i.cs_fall) st_d.cnt = '0;
        if (evt_i.sclk_rise && evt_i.sel) begin
            st_d.sr    = {st_q.sr[FRAME_W-2:0], evt_i.sdi};
            st_d.spill = st_q.sr[FRAME_W-1];
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
        end
        if (evt_i.sclk_fall && evt_i.sel) st_d.sdo = st_q.spill;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // the latch sees this cycle's shift (R9)
    assign win_o = st_d.sr[SHORT_W-1:0];
    assign cnt_o = st_d.cnt;
    assign sdo_o = st_q.sdo;

    a_r8_sdo_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.sdo) |-> $past(evt_i.sclk_fall && evt_i.sel));

    a_r5_idle_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i.sclk_rise && !evt_i.sel) |=> $stable(st_q.sr));

    a_r5_idle_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_i.sel && !evt_i.cs_fall) |=> $stable(st_q.cnt));
endmodule

// File: rtl/sdac_latch.sv
module sdac_latch #(
    parameter int CODE_W  = 10,
    parameter int SUB_W   = 2,
    parameter int FRAME_W = 16,
    parameter int CNT_W   = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_rise_i,
    input  logic [CODE_W+SUB_W-1:0]   win_i,
    input  logic [CNT_W-1:0]          cnt_i,
    output logic [CODE_W-1:0]         code_o,
    output logic                      load_o,
    output logic                      err_o
);
    localparam int SHORT_W = CODE_W + SUB_W;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              load;
        logic              err;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.load = 1'b0;
        if (cs_rise_i) begin
            st_d.code = win_i[SHORT_W-1:SUB_W];
            st_d.load = 1'b1;
            st_d.err  = (cnt_i != CNT_W'(SHORT_W)) && (cnt_i != CNT_W'(FRAME_W));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_o = st_q.code;
    assign load_o = st_q.load;
    assign err_o  = st_q.err;

    a_r6_code_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.code) |-> st_q.load);

    a_r6_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.load |=> !st_q.load);

    a_r7_err_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.err) |-> st_q.load);
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend
    import sdac_pkg::*;
#(
    parameter int CODE_W      = 10,
    parameter int SUB_W       = 2,
    parameter int FRAME_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              csn_i,
    output logic              sdo_o,
    output logic [CODE_W-1:0] code_o,
    output logic              load_o,
    output logic              frame_err_o
);
    localparam int SHORT_W = CODE_W + SUB_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1) + 1;

    pins_t                raw_pins, sync_pins;
    evt_t                 evt;
    logic [SHORT_W-1:0]   win;
    logic [CNT_W-1:0]     cnt;

    assign raw_pins = '{csn: csn_i, sclk: sclk_i, sdi: sdi_i};

    sdac_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .pins_i(raw_pins), .pins_o(sync_pins)
    );

    sdac_edge i_edge (
        .clk(clk), .rst_n(rst_n), .now_i(sync_pins), .evt_o(evt)
    );

    sdac_shift #(.FRAME_W(FRAME_W), .SHORT_W(SHORT_W), .CNT_W(CNT_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .evt_i(evt),
        .win_o(win), .cnt_o(cnt), .sdo_o(sdo_o)
    );

    sdac_latch #(.CODE_W(CODE_W), .SUB_W(SUB_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) i_latch (
        .clk(clk), .rst_n(rst_n), .cs_rise_i(evt.cs_rise),
        .win_i(win), .cnt_i(cnt),
        .code_o(code_o), .load_o(load_o), .err_o(frame_err_o)
    );
endmodule

// File: tb/test_sdac_frontend.sv
module test_sdac_frontend;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0, sclk = 1'b0, sdi = 1'b0, csn = 1'b1;
    logic sdo, load, ferr;
    logic [9:0] code;

    sdac_frontend i_sdac_frontend (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .csn_i(csn),
        .sdo_o(sdo), .code_o(code), .load_o(load), .frame_err_o(ferr)
    );

    int n_run = 0, n_fail = 0;
    bit done = 0;

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model: pins reach the edge logic two cycles late
    logic [2:0] hist[$];
    bit         m_sr[$];
    int         m_cnt, m_code;
    bit         m_pend, m_sdo, m_load, m_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = {3'b100, 3'b100, 3'b100, 3'b100};
            m_sr = {};
            for (int i = 0; i < 16; i++) m_sr.push_back(1'b0);
            m_cnt = 0; m_code = 0; m_pend = 0; m_sdo = 0; m_load = 0; m_err = 0;
        end else begin
            logic [2:0] cur, prv;
            hist.push_front({csn, sclk, sdi});
            cur = hist[2];
            prv = hist[3];
            void'(hist.pop_back());
            m_load = 0;
            if (!cur[2] && prv[2]) m_cnt = 0;
            if (cur[1] && !prv[1] && !prv[2]) begin
                m_pend = m_sr.pop_front();
                m_sr.push_back(cur[0]);
                if (m_cnt < 63) m_cnt++;
            end
            if (!cur[1] && prv[1] && !prv[2]) m_sdo = m_pend;
            if (cur[2] && !prv[2]) begin
                m_code = 0;
                for (int i = 0; i < 10; i++) m_code[9-i] = m_sr[4+i];
                m_err  = !(m_cnt == 12 || m_cnt == 16);
                m_load = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 code_o model", code, m_code);
            check("R6 load_o model", load, m_load);
            check("R7 frame_err_o model", ferr, m_err);
            check("R8 sdo_o model", sdo, m_sdo);
        end
    end

    // directed stimulus
    bit stream[$];
    int seen[16];

    task automatic waitn(int k);
        repeat (k) @(negedge clk);
    endtask

    function automatic int exp_code();
        int c = 0;
        int s = stream.size();
        for (int i = 0; i < 10; i++) c[9-i] = stream[s-12+i];
        return c;
    endfunction

    // tail: 0 normal, 1 select rises with last fall, 2 select rises with last rise
    task automatic frame(input logic [15:0] bits, input int n, input int tail, input bit chk_lat);
        int old_code;
        old_code = code;
        csn = 1'b0;
        waitn(3);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i];
            stream.push_back(bits[i]);
            waitn(3);
            sclk = 1'b1;
            if (i == 0 && tail == 2) csn = 1'b1;
            waitn(3);
            sclk = 1'b0;
            if (i == 0 && tail == 1) csn = 1'b1;
            waitn(3);
            seen[n-1-i] = sdo;
        end
        if (tail == 0) begin
            csn = 1'b1;
            if (chk_lat) begin
                waitn(2);
                check("R6 no load before third edge", load, 0);
                check("R6 code held before third edge", code, old_code);
                waitn(1);
                check("R6 load at third edge", load, 1);
                waitn(1);
                check("R6 load one cycle", load, 0);
            end
        end
        waitn(6);
    endtask

    int c1;

    initial begin
        waitn(3);
        check("R1 code reset", code, 0);
        check("R1 load reset", load, 0);
        check("R1 err reset", ferr, 0);
        check("R1 sdo reset", sdo, 0);
        rst_n = 1'b1;
        waitn(4);

        // R2: 16-bit frame
        frame(16'hA5C3, 16, 0, 1);
        check("R2 code 16-bit frame", code, exp_code());
        check("R2 code value", code, (16'hA5C3 >> 2) & 10'h3FF);
        check("R7 err 16-bit", ferr, 0);

        // R3: 12-bit frame
        frame(16'h0E71, 12, 0, 1);
        check("R3 code 12-bit frame", code, (16'h0E71 >> 2) & 10'h3FF);
        check("R7 err 12-bit", ferr, 0);

        // R4: dummy and sub-LSB bits differ, code equal
        frame(16'h0550, 16, 0, 0);
        c1 = code;
        frame(16'hF553, 16, 0, 0);
        check("R4 dummy and sub-LSB ignored", code, c1);

        // R8 + R5: chained output, with idle clocking between frames
        frame(16'h9B2D, 16, 0, 0);
        sclk = 1'b0;
        for (int k = 0; k < 5; k++) begin
            sdi = k[0];
            waitn(3); sclk = 1'b1; waitn(3); sclk = 1'b0;
        end
        waitn(4);
        check("R5 sdo held while idle", sdo, 1);
        check("R5 code held while idle", code, (16'h9B2D >> 2) & 10'h3FF);
        frame(16'h3C6E, 16, 0, 0);
        for (int k = 0; k < 16; k++) begin
            logic [15:0] a = 16'h9B2D;
            check("R8 chained bit", seen[k], a[15-k]);
        end

        // R9: final fall together with select rise
        frame(16'h4C1F, 16, 1, 0);
        check("R9 last fall drives sdo", seen[15], 0);
        check("R9 code after fall-latch", code, (16'h4C1F >> 2) & 10'h3FF);

        // R9: final rise together with select rise
        frame(16'h0B6D, 12, 2, 0);
        check("R9 last rise counted", ferr, 0);
        check("R9 last rise shifted", code, (16'h0B6D >> 2) & 10'h3FF);

        // R7: bad counts
        frame(16'h2A97, 14, 0, 0);
        check("R7 err 14-bit", ferr, 1);
        check("R7 code 14-bit", code, exp_code());
        frame(16'h0193, 11, 0, 0);
        check("R7 err 11-bit", ferr, 1);
        check("R7 code uses earlier bits", code, exp_code());
        frame(16'hC3A5, 16, 0, 0);
        check("R7 err clears", ferr, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule